// File: doc/BRIEF.md
# Serial Command and Status Port for a Power Switch

This block is the serial slave front end of a power-switch controller. A host frames each transaction with an active-low chip select, drives command bits on the serial input most significant bit first on rising serial-clock edges, and at the same time receives an eight-bit status byte on the serial output, which changes on falling serial-clock edges. The status byte is loaded when chip select falls. Which byte is loaded depends on the status-select field of the most recent accepted status-select command, so a read always reports what the previous transaction asked for.

When chip select rises, the block counts the rising serial-clock edges in the frame. A frame is accepted only when that count is a non-zero multiple of eight. Only the last complete byte of an accepted frame is decoded: its upper nibble is the address and its lower nibble is the data. Once the status byte has been shifted out, the serial output repeats the bits that arrived on the serial input, so several devices can share one chain and the host can verify what it sent. A frame of any other length is discarded, and every register and every fault flag is left as if that frame had never happened.

Fault events set sticky flags. A flag is cleared only when it was shifted out in a fault report and the frame carrying that report was accepted. Under-voltage and over-voltage reporting can each be switched off.

Top module: `spi_cmd_status_if`

## Requirements
- R1: After reset `so_oe` is 0, the status select is 000, the watchdog bit, configuration bits, both protection-disable bits and all fault flags are 0.
- R2: `so_oe` is 1 from the first clock after chip select is sampled low until the first clock after it is sampled high, and 0 otherwise. `so_data` shows the most significant status bit first and advances one bit on each falling serial-clock edge.
- R3: Bit 7 of every status byte is the watchdog bit, which is written by address 0010 from data bit 0.
- R4: With status select 000, bits 6..0 of the status byte are the reported fault flags: bit 1 is under-voltage and bit 0 is over-voltage.
- R5: With status select 001, bits 6..0 are {000, configuration[3:0]}. The configuration is written by address 0001 and appears on `cfg_bits`. Bit 1 is the current-sense enable and bit 0 is the serial input-control bit.
- R6: With status select 010, bits 6..0 are {00000, under-voltage disable, over-voltage disable}. Status selects 011 to 111 return 0 in bits 6..0.
- R7: A frame is valid when its count of rising serial-clock edges is a non-zero multiple of 8. The last 8 bits received form the command: bits 7..4 are the address and bits 3..0 are the data. Address 0000 sets the status select to data[2:0]. Commands take effect in the clock after chip select is sampled high.
- R8: A frame of invalid length changes no register, no status select and no fault flag.
- R9: After the eight status bits, `so_data` outputs the serial input bits of the frame in the order they arrived.
- R10: Address 1110 writes the under-voltage disable from data bit 1 and the over-voltage disable from data bit 0. While a disable bit is 1, the matching fault flag is neither set nor reported.
- R11: Writes to addresses 0111 and 1111 (test space) and to any address that is not assigned change nothing.
- R12: A fault flag is set by a 1 on its `fault_evt` bit in any clock. It is cleared at the end of a valid frame only if that frame loaded status select 000 at chip-select fall and the flag was reported in that byte. Flags that are set during the frame stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| fault_evt | input | 7 | Fault event strobes, bit 1 under-voltage, bit 0 over-voltage |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for serial data out; 0 means high impedance |
| cfg_bits | output | 4 | Programmed configuration bits |
| wd_bit | output | 1 | Last written watchdog bit |
| uv_off | output | 1 | Under-voltage reporting disabled |
| ov_off | output | 1 | Over-voltage reporting disabled |

## Verification
The bench builds the block with the default parameters: 8-bit words, 4-bit address and data nibbles, a 7-bit fault field and an 8-bit frame counter. With these values, frames of 7, 8, 12 and 16 bits are all reachable in a short run, and they cover the length boundary, the choice of the last word as the command and the chained pass-through. The 7-bit fault field lets the bench place events on the under-voltage and over-voltage positions as well as on higher flags, both during a frame and between frames, which exercises the masking and the clear-on-report rules.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 4;
    localparam int SEL_W  = 3;
    localparam int FLT_W  = BYTE_W - 1;
    localparam int UV_POS = 1;
    localparam int OV_POS = 0;

    localparam logic [ADDR_W-1:0] A_STATSEL = 4'b0000;
    localparam logic [ADDR_W-1:0] A_CONFIG  = 4'b0001;
    localparam logic [ADDR_W-1:0] A_WDOG    = 4'b0010;
    localparam logic [ADDR_W-1:0] A_PROT    = 4'b1110;

    typedef enum logic [SEL_W-1:0] {
        SEL_FAULT = 3'd0,
        SEL_CFG   = 3'd1,
        SEL_PROT  = 3'd2
    } stat_sel_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              wd;
        logic [DATA_W-1:0] cfg;
        logic              uv_dis;
        logic              ov_dis;
    } ctl_regs_t;

    function automatic logic is_test_addr(input logic [ADDR_W-1:0] a);
        return a[2:0] == 3'b111;
    endfunction

    function automatic logic [FLT_W-1:0] prot_mask(input logic uv_dis, input logic ov_dis);
        logic [FLT_W-1:0] m;
        m = '1;
        m[UV_POS] = ~uv_dis;
        m[OV_POS] = ~ov_dis;
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input ctl_regs_t r,
                                                      input logic [FLT_W-1:0] flt);
        logic [FLT_W-1:0] low;
        case (r.sel)
            SEL_FAULT: low = flt;
            SEL_CFG:   low = FLT_W'(r.cfg);
            SEL_PROT:  low = FLT_W'({r.uv_dis, r.ov_dis});
            default:   low = '0;
        endcase
        return {r.wd, low};
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int BYTE_W = spi_cmd_pkg::BYTE_W,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              cs_fall,
    output logic              frame_end,
    output logic              frame_ok,
    output logic [BYTE_W-1:0] rx_word,
    output logic              so_data,
    output logic              so_oe
);
    localparam int LSB_W = $clog2(BYTE_W);

    logic              sclk_q, cs_n_q, active_q, any_q, si_lat_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] rx_q, sr_q;
    logic              cs_rise, sck_rise, sck_fall;

    assign cs_fall  = cs_n_q & ~cs_n;
    assign cs_rise  = ~cs_n_q & cs_n;
    assign sck_rise = sclk & ~sclk_q;
    assign sck_fall = ~sclk & sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            active_q <= 1'b0;
            any_q    <= 1'b0;
            si_lat_q <= 1'b0;
            cnt_q    <= '0;
            rx_q     <= '0;
            sr_q     <= '0;
        end else begin
            sclk_q <= sclk;
            cs_n_q <= cs_n;
            if (cs_fall) begin
                sr_q     <= load_byte;
                cnt_q    <= '0;
                any_q    <= 1'b0;
                active_q <= 1'b1;
            end else if (cs_rise) begin
                active_q <= 1'b0;
            end else if (active_q) begin
                if (sck_rise) begin
                    rx_q     <= {rx_q[BYTE_W-2:0], si};
                    si_lat_q <= si;
                    cnt_q    <= cnt_q + CNT_W'(1);
                    any_q    <= 1'b1;
                end
                if (sck_fall) begin
                    sr_q <= {sr_q[BYTE_W-2:0], si_lat_q};
                end
            end
        end
    end

    assign frame_end = cs_rise & active_q;
    assign frame_ok  = any_q && (cnt_q[LSB_W-1:0] == '0);
    assign rx_word   = rx_q;
    assign so_data   = sr_q[BYTE_W-1];
    assign so_oe     = active_q;

    // R2: output released once chip select has been high for two samples
    assert_so_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !so_oe);

    // R7: the bit counter advances by at most one per clock within a frame
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
        (active_q && !cs_rise) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_cmd_pkg::*;
#(
    parameter int BYTE_W = spi_cmd_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic              frame_ok,
    input  logic [BYTE_W-1:0] word,
    output ctl_regs_t         regs
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              take;
    ctl_regs_t         regs_q;

    assign addr = word[BYTE_W-1 -: ADDR_W];
    assign data = word[DATA_W-1:0];
    assign take = frame_end & frame_ok & ~is_test_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (take) begin
            case (addr)
                A_STATSEL: regs_q.sel <= data[SEL_W-1:0];
                A_CONFIG:  regs_q.cfg <= data;
                A_WDOG:    regs_q.wd  <= data[0];
                A_PROT: begin
                    regs_q.uv_dis <= data[1];
                    regs_q.ov_dis <= data[0];
                end
                default: ;
            endcase
        end
    end

    assign regs = regs_q;

    // R8: a frame of bad length leaves every control register alone
    assert_bad_len_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !frame_ok) |=> $stable(regs_q));

    // R11: test-space addresses never modify the registers
    assert_test_space_R11: assert property (@(posedge clk) disable iff (rst)
        (frame_end && word[BYTE_W-2 -: 3] == 3'b111) |=> $stable(regs_q));

endmodule

// File: rtl/spi_fault_reg.sv
module spi_fault_reg
    import spi_cmd_pkg::*;
#(
    parameter int FLT_W = spi_cmd_pkg::FLT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FLT_W-1:0] evt,
    input  logic             uv_dis,
    input  logic             ov_dis,
    input  logic             snap,
    input  logic             snap_is_fault,
    input  logic             end_ok,
    output logic [FLT_W-1:0] reported
);
    logic [FLT_W-1:0] flt_q, capt_q, mask, set_v;

    assign mask     = prot_mask(uv_dis, ov_dis);
    assign set_v    = evt & mask;
    assign reported = flt_q & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q  <= '0;
            capt_q <= '0;
        end else begin
            if (snap) begin
                capt_q <= snap_is_fault ? reported : '0;
            end
            if (end_ok) begin
                flt_q <= (flt_q & ~capt_q) | set_v;
            end else begin
                flt_q <= flt_q | set_v;
            end
        end
    end

    // R12: outside an accepted frame end, no flag ever drops
    assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        !end_ok |=> ((flt_q & $past(flt_q)) == $past(flt_q)));

endmodule

// File: rtl/spi_cmd_status_if.sv
module spi_cmd_status_if
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_si,
    input  logic [FLT_W-1:0] fault_evt,
    output logic             so_data,
    output logic             so_oe,
    output logic [DATA_W-1:0] cfg_bits,
    output logic             wd_bit,
    output logic             uv_off,
    output logic             ov_off
);
    ctl_regs_t         regs;
    logic [FLT_W-1:0]  flt_rep;
    logic [BYTE_W-1:0] status, rx_word;
    logic              cs_fall, frame_end, frame_ok;

    assign status = status_byte(regs, flt_rep);

    spi_frame_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .si        (spi_si),
        .load_byte (status),
        .cs_fall   (cs_fall),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .rx_word   (rx_word),
        .so_data   (so_data),
        .so_oe     (so_oe)
    );

    spi_ctl_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .word      (rx_word),
        .regs      (regs)
    );

    spi_fault_reg #(.FLT_W(FLT_W)) u_flt (
        .clk           (clk),
        .rst           (rst),
        .evt           (fault_evt),
        .uv_dis        (regs.uv_dis),
        .ov_dis        (regs.ov_dis),
        .snap          (cs_fall),
        .snap_is_fault (regs.sel == SEL_FAULT),
        .end_ok        (frame_end & frame_ok),
        .reported      (flt_rep)
    );

    assign cfg_bits = regs.cfg;
    assign wd_bit   = regs.wd;
    assign uv_off   = regs.uv_dis;
    assign ov_off   = regs.ov_dis;

    // R3: the first bit driven in a frame is the watchdog bit
    assert_wd_msb_R3: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (so_oe && so_data == $past(regs.wd)));

endmodule

// File: tb/spi_cmd_status_if_test.sv
module spi_cmd_status_if_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic [6:0] fevt = '0;
    logic       so_data, so_oe, wd_bit, uv_off, ov_off;
    logic [3:0] cfg_bits;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    spi_cmd_status_if uut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_si(si),
        .fault_evt(fevt), .so_data(so_data), .so_oe(so_oe), .cfg_bits(cfg_bits),
        .wd_bit(wd_bit), .uv_off(uv_off), .ov_off(ov_off)
    );

    // behavioural reference model
    bit       m_oe, m_wd, m_uv, m_ov;
    bit [2:0] m_sel;
    bit [3:0] m_cfg;
    bit [6:0] m_flt, m_capt;
    bit [7:0] m_rx;
    int       m_cnt;
    bit       p_cs = 1, p_sck = 0;
    bit       so_q[$];

    function automatic bit [6:0] m_mask();
        bit [6:0] k = 7'h7f;
        k[1] = !m_uv;
        k[0] = !m_ov;
        return k;
    endfunction

    function automatic bit [7:0] m_status();
        bit [6:0] lo;
        case (m_sel)
            3'd0: lo = m_flt & m_mask();
            3'd1: lo = {3'b000, m_cfg};
            3'd2: lo = {5'b00000, m_uv, m_ov};
            default: lo = '0;
        endcase
        return {m_wd, lo};
    endfunction

    always @(posedge clk) begin
        bit [6:0] ev;
        bit [7:0] st;
        #1;
        if (rst) begin
            m_oe = 0; m_wd = 0; m_uv = 0; m_ov = 0; m_sel = 0; m_cfg = 0;
            m_flt = 0; m_capt = 0; m_rx = 0; m_cnt = 0; p_cs = 1; p_sck = 0;
            so_q.delete();
        end else begin
            ev = fevt & m_mask();
            if (p_cs && !cs_n) begin
                st = m_status();
                so_q.delete();
                for (int i = 7; i >= 0; i--) so_q.push_back(st[i]);
                m_capt = (m_sel == 0) ? (m_flt & m_mask()) : 7'd0;
                m_cnt = 0;
                m_oe = 1;
                m_flt = m_flt | ev;
            end else if (!p_cs && cs_n) begin
                m_oe = 0;
                so_q.delete();
                if (m_cnt > 0 && m_cnt % 8 == 0) begin
                    m_flt = (m_flt & ~m_capt) | ev;
                    case (m_rx[7:4])
                        4'b0000: m_sel = m_rx[2:0];
                        4'b0001: m_cfg = m_rx[3:0];
                        4'b0010: m_wd = m_rx[0];
                        4'b1110: begin m_uv = m_rx[1]; m_ov = m_rx[0]; end
                        default: ;
                    endcase
                end else begin
                    m_flt = m_flt | ev;
                end
            end else begin
                m_flt = m_flt | ev;
                if (!cs_n && m_oe) begin
                    if (sclk && !p_sck) begin
                        so_q.push_back(si);
                        m_rx = {m_rx[6:0], si};
                        m_cnt++;
                    end
                    if (!sclk && p_sck && so_q.size() > 0) void'(so_q.pop_front());
                end
            end
            p_cs = cs_n;
            p_sck = sclk;
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            check(cur_req, "so_oe", so_oe, m_oe);
            if (m_oe && so_q.size() > 0) check(cur_req, "so_data", so_data, so_q[0]);
            check(cur_req, "cfg_bits", cfg_bits, m_cfg);
            check(cur_req, "wd_bit", wd_bit, m_wd);
            check(cur_req, "uv_off", uv_off, m_uv);
            check(cur_req, "ov_off", ov_off, m_ov);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input int nbits, input logic [31:0] bits);
        @(negedge clk) cs_n = 1'b0;
        idle(3);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk) si = bits[i];
            idle(2);
            @(negedge clk) sclk = 1'b1;
            idle(2);
            @(negedge clk) sclk = 1'b0;
            idle(2);
        end
        @(negedge clk) cs_n = 1'b1;
        idle(4);
    endtask

    task automatic pulse(input logic [6:0] v);
        @(negedge clk) fevt = v;
        @(negedge clk) fevt = '0;
    endtask

    // explicit byte read: frame carrying cmd, status byte checked via SO
    task automatic read_expect(input string req, input logic [7:0] cmd, input logic [7:0] exp);
        logic [7:0] got;
        @(negedge clk) cs_n = 1'b0;
        idle(3);
        for (int i = 7; i >= 0; i--) begin
            got[i] = so_data;
            @(negedge clk) si = cmd[i];
            idle(2);
            @(negedge clk) sclk = 1'b1;
            idle(2);
            @(negedge clk) sclk = 1'b0;
            idle(2);
        end
        @(negedge clk) cs_n = 1'b1;
        idle(4);
        check(req, "status byte", got, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(2);
        // R1: reset state at the ports
        cur_req = "R1";
        check("R1", "so_oe after reset", so_oe, 0);
        check("R1", "cfg after reset", cfg_bits, 0);
        read_expect("R1", 8'h00, 8'h00);

        // R3 watchdog bit then R2 timing of a plain read
        cur_req = "R3";
        frame(8, 32'h21);
        read_expect("R3", 8'h00, 8'h80);

        // R5 config and select 001, R7 decode
        cur_req = "R5";
        frame(8, 32'h1B);
        frame(8, 32'h01);
        read_expect("R5", 8'h01, 8'h8B);

        // R9 chained 16-bit frame, last word is the command
        cur_req = "R9";
        frame(16, 32'hA5_00);
        cur_req = "R7";
        read_expect("R7", 8'h00, 8'h80);

        // R4 and R12 fault reporting and clear-on-report
        cur_req = "R4";
        pulse(7'b1000100);
        read_expect("R4", 8'h00, 8'hC4);
        cur_req = "R12";
        read_expect("R12", 8'h00, 8'h80);
        @(negedge clk) cs_n = 1'b0;
        idle(3);
        pulse(7'b0010000);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) si = 1'b0;
            @(negedge clk) sclk = 1'b1;
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk) cs_n = 1'b1;
        idle(4);
        read_expect("R12", 8'h00, 8'h90);

        // R8 invalid lengths keep everything, including pending faults
        cur_req = "R8";
        pulse(7'b0000010);
        frame(7, 32'h01);
        frame(12, 32'h1F3);
        read_expect("R8", 8'h00, 8'h82);
        check("R8", "cfg kept", cfg_bits, 4'hB);

        // R10 protection disables
        cur_req = "R10";
        frame(8, 32'hE3);
        frame(8, 32'h02);
        read_expect("R10", 8'h00, 8'h83);
        pulse(7'b0000011);
        read_expect("R10", 8'h00, 8'h80);
        frame(8, 32'hE0);
        pulse(7'b0000011);
        read_expect("R10", 8'h00, 8'h83);

        // R11 test space and unassigned addresses
        cur_req = "R11";
        frame(8, 32'h7F);
        frame(8, 32'hF0);
        frame(8, 32'h35);
        frame(8, 32'h01);
        read_expect("R11", 8'h01, 8'h8B);
        check("R11", "cfg unchanged", cfg_bits, 4'hB);

        // R6 select 010 and the zero-filled selects
        cur_req = "R6";
        frame(8, 32'hE2);
        frame(8, 32'h02);
        read_expect("R6", 8'h05, 8'h82);
        read_expect("R6", 8'h00, 8'h80);

        // R2: chip select high, output released
        cur_req = "R2";
        idle(3);
        check("R2", "so_oe idle", so_oe, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule